// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block gives boot firmware a narrow register window onto a table of read-only configuration items. Software writes a 16-bit key to a control register to choose one item; it then reads the item's bytes through a data register. The port keeps a running byte offset into the chosen item. Each byte delivered moves the offset forward by one, so repeated reads walk through the item. Keys are split into a bank flag and an index. One bank holds generic items and the other holds architecture-local items. A key that indexes past the end of its bank leaves the port with no valid selection.

Item storage is an on-chip table sized by elaboration parameters. Each slot has a base address in a byte store, a length and a present flag. A parameter selects one of two register layouts. In the split layout, control and data are separate ports. In the combined layout, a single narrow window serves both: byte accesses go to data, and 2-byte writes select an item. Every access is handled by a small state machine. The machine has three states. IDLE accepts an access. FETCH gathers one byte lane per cycle for a read. RESP raises the one-cycle completion pulse. The transitions are: IDLE to FETCH on an accepted data read, IDLE to RESP on any other access, FETCH to FETCH while lanes remain, FETCH to RESP after the last lane, and RESP to IDLE.

Top module: `cfg_sel_port`

## Requirements
- R1: In the split layout, a 2-byte write to the control port (`acc_port`=0) selects an item and sets the offset to zero. Bit 14 of the key picks the arch-local bank when set, bits 13:0 are the index, and bit 15 is ignored.
- R2: In the split layout, a control read, or a control write of any size other than 2, is rejected (`acc_ok`=0) and leaves the selection and the offset unchanged.
- R3: A key whose index is not below the entry count of its bank (GEN_ENTRIES or ARCH_ENTRIES) makes the selection invalid, and every later data read returns zero until the next valid select.
- R4: A data read of N bytes (1 to DATA_BYTES) places the item bytes from the current offset into the N low lanes, earliest byte most significant. The offset grows by one for each byte taken.
- R5: When an item ends partway through a read, the remaining low lanes read as zero. The offset stops at the item length, and a read at the end returns zero with the offset unchanged.
- R6: Data writes are accepted (`acc_ok`=1) and ignored: the item contents and the offset are unaffected.
- R7: When COMBINED=1, `acc_port` is ignored. A 1-byte access is a data access, a 2-byte write is a select, and any other access is rejected.
- R8: Reset selects generic index 0 at offset 0, and that item reads as the four bytes 0x51 0x45 0x4D 0x55.
- R9: Generic index 1 is a 4-byte little-endian identification word: bit 0 is set always, and bit 1 equals DMA_EN. With DMA_EN=1, a 4-byte read returns 0x03000000.
- R10: Generic index 2 is absent and reads as zero. Every other item at bank b, index k has length ((k + 5*b) mod MAX_LEN) + 1, and its byte at offset o is (b<<7) | ((k&7)<<4) | (o&15).
- R11: Each access ends with `acc_done` high for exactly one cycle. `acc_rdata` is zero except on a completed read, and `acc_ok` is low outside `acc_done`.
- R12: A data read of size 0, or of a size larger than DATA_BYTES, is rejected and leaves the offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request, taken while the port is idle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_port | input | 1 | 0 selects the control register, 1 the data register (split layout only) |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 16 | Write data; the key on a select |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_ok | output | 1 | Access accepted, valid with acc_done |
| acc_rdata | output | 8*DATA_BYTES | Read result, valid with acc_done |

## Verification
The bench builds two instances. The first uses the split layout with 8 generic and 4 arch-local slots, a 12-byte maximum length, 4-byte reads and DMA_EN=1. This instance reaches multi-byte packing, zero padding at item ends, out-of-range keys in both banks and the rejected control accesses. The second uses the combined layout with only 2 arch-local slots, a 10-byte maximum and DMA_EN=0. That brings the byte-versus-word decoding, the cleared identification bit and a smaller arch bank boundary within reach of the same tests.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RESP
    } port_state_t;

    typedef enum logic [1:0] {
        ACC_REJECT,
        ACC_SELECT,
        ACC_READ,
        ACC_IGNORE
    } acc_kind_t;

    localparam int KEY_IDX_W = 14;
    localparam int KEY_BANK_BIT = 14;
    localparam int OFF_W = 32;

    // Length of the item in a given bank slot.
    function automatic int item_len_f(input bit bank, input int k, input int max_len);
        if (!bank && k < 2)  return 4;
        if (!bank && k == 2) return 0;
        return ((k + 5 * int'(bank)) % max_len) + 1;
    endfunction

    function automatic bit item_present_f(input bit bank, input int k);
        return !(!bank && k == 2);
    endfunction

    // Content byte of an item at a given offset.
    function automatic logic [7:0] item_byte_f(input bit bank, input int k,
                                               input int o, input bit dma);
        if (!bank && k == 0) begin
            case (o)
                0:       return 8'h51;
                1:       return 8'h45;
                2:       return 8'h4D;
                3:       return 8'h55;
                default: return 8'h00;
            endcase
        end
        if (!bank && k == 1)
            return (o == 0) ? {6'b0, dma, 1'b1} : 8'h00;
        return {bank, 3'(k), 4'(o)};
    endfunction

endpackage

// File: rtl/cfg_item_table.sv
module cfg_item_table
    import cfg_port_pkg::*;
#(
    parameter int GEN_ENTRIES  = 8,
    parameter int ARCH_ENTRIES = 4,
    parameter int MAX_LEN      = 12,
    localparam int SLOTS  = GEN_ENTRIES + ARCH_ENTRIES,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int ADDR_W = $clog2(SLOTS * MAX_LEN)
) (
    input  logic                 sel_ok,
    input  logic                 sel_bank,
    input  logic [KEY_IDX_W-1:0] sel_idx,
    output logic                 item_present,
    output logic [LEN_W-1:0]     item_len,
    output logic [ADDR_W-1:0]    item_base
);

    logic [LEN_W-1:0] len_tab  [SLOTS];
    logic             pres_tab [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam bit BANK = (s >= GEN_ENTRIES);
        localparam int IDX  = BANK ? s - GEN_ENTRIES : s;
        assign len_tab[s]  = LEN_W'(item_len_f(BANK, IDX, MAX_LEN));
        assign pres_tab[s] = item_present_f(BANK, IDX);
    end

    logic              in_rng;
    logic [SLOT_W-1:0] slot_sel;

    always_comb begin
        in_rng = sel_bank ? (int'(sel_idx) < ARCH_ENTRIES)
                          : (int'(sel_idx) < GEN_ENTRIES);
        slot_sel = '0;
        if (in_rng)
            slot_sel = sel_bank ? SLOT_W'(GEN_ENTRIES + int'(sel_idx))
                                : SLOT_W'(sel_idx);
        item_present = sel_ok && in_rng && pres_tab[slot_sel];
        item_len     = item_present ? len_tab[slot_sel] : '0;
        item_base    = ADDR_W'(int'(slot_sel) * MAX_LEN);
    end

endmodule

// File: rtl/cfg_byte_rom.sv
module cfg_byte_rom
    import cfg_port_pkg::*;
#(
    parameter int GEN_ENTRIES  = 8,
    parameter int ARCH_ENTRIES = 4,
    parameter int MAX_LEN      = 12,
    parameter bit DMA_EN       = 1'b1,
    localparam int SLOTS  = GEN_ENTRIES + ARCH_ENTRIES,
    localparam int DEPTH  = SLOTS * MAX_LEN,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte
);

    logic [7:0] rom [DEPTH];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam bit BANK = (s >= GEN_ENTRIES);
        localparam int IDX  = BANK ? s - GEN_ENTRIES : s;
        for (genvar o = 0; o < MAX_LEN; o++) begin : g_byte
            assign rom[s * MAX_LEN + o] = item_byte_f(BANK, IDX, o, DMA_EN);
        end
    end

    assign rd_byte = (int'(rd_addr) < DEPTH) ? rom[rd_addr] : 8'h00;

endmodule

// File: rtl/cfg_sel_fsm.sv
module cfg_sel_fsm
    import cfg_port_pkg::*;
#(
    parameter int GEN_ENTRIES  = 8,
    parameter int ARCH_ENTRIES = 4,
    parameter int MAX_LEN      = 12,
    parameter int DATA_BYTES   = 4,
    parameter bit COMBINED     = 1'b0,
    localparam int LEN_W = $clog2(MAX_LEN + 1),
    localparam int CNT_W = $clog2(DATA_BYTES + 1),
    localparam int DW    = 8 * DATA_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic                 acc_port,
    input  logic [2:0]           acc_size,
    input  logic [15:0]          acc_wdata,
    input  logic                 item_present,
    input  logic [LEN_W-1:0]     item_len,
    input  logic [7:0]           item_byte,
    output logic                 sel_ok,
    output logic                 sel_bank,
    output logic [KEY_IDX_W-1:0] sel_idx,
    output logic [OFF_W-1:0]     sel_off,
    output logic                 fsm_idle,
    output logic                 acc_done,
    output logic                 acc_ok,
    output logic [DW-1:0]        acc_rdata
);

    port_state_t          st_q, st_d;
    acc_kind_t            kind;
    logic [CNT_W-1:0]     left_q;
    logic [DW-1:0]        shr_q;
    logic                 ok_q;
    logic                 key_in_rng;
    logic                 avail;
    logic                 unused_key_hi;

    assign unused_key_hi = acc_wdata[15];

    // Decode the incoming access.
    always_comb begin
        kind = ACC_REJECT;
        if (COMBINED) begin
            if (acc_size == 3'd1)
                kind = acc_write ? ACC_IGNORE : ACC_READ;
            else if (acc_size == 3'd2 && acc_write)
                kind = ACC_SELECT;
        end else if (!acc_port) begin
            if (acc_write && acc_size == 3'd2)
                kind = ACC_SELECT;
        end else if (acc_size != 3'd0 && int'(acc_size) <= DATA_BYTES) begin
            kind = acc_write ? ACC_IGNORE : ACC_READ;
        end
        key_in_rng = acc_wdata[KEY_BANK_BIT]
                   ? (int'(acc_wdata[KEY_IDX_W-1:0]) < ARCH_ENTRIES)
                   : (int'(acc_wdata[KEY_IDX_W-1:0]) < GEN_ENTRIES);
        avail = sel_ok && item_present && (sel_off < OFF_W'(item_len));
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (acc_valid) st_d = (kind == ACC_READ) ? ST_FETCH : ST_RESP;
            ST_FETCH: if (left_q == CNT_W'(1)) st_d = ST_RESP;
            ST_RESP:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Selection, offset and lane gathering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_ok   <= 1'b1;
            sel_bank <= 1'b0;
            sel_idx  <= '0;
            sel_off  <= '0;
            shr_q    <= '0;
            ok_q     <= 1'b0;
            left_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (acc_valid) begin
                        ok_q   <= (kind != ACC_REJECT);
                        shr_q  <= '0;
                        left_q <= CNT_W'(acc_size);
                        if (kind == ACC_SELECT) begin
                            sel_bank <= acc_wdata[KEY_BANK_BIT];
                            sel_idx  <= acc_wdata[KEY_IDX_W-1:0];
                            sel_ok   <= key_in_rng;
                            sel_off  <= '0;
                        end
                    end
                end
                ST_FETCH: begin
                    shr_q  <= (shr_q << 8) | DW'(avail ? item_byte : 8'h00);
                    left_q <= left_q - CNT_W'(1);
                    if (avail) sel_off <= sel_off + OFF_W'(1);
                end
                ST_RESP: begin
                    left_q <= '0;
                end
                default: begin
                    left_q <= '0;
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        fsm_idle  = (st_q == ST_IDLE);
        acc_done  = (st_q == ST_RESP);
        acc_ok    = acc_done && ok_q;
        acc_rdata = acc_done ? shr_q : '0;
    end

endmodule

// File: rtl/cfg_sel_port.sv
module cfg_sel_port
    import cfg_port_pkg::*;
#(
    parameter int GEN_ENTRIES  = 8,
    parameter int ARCH_ENTRIES = 4,
    parameter int MAX_LEN      = 12,
    parameter int DATA_BYTES   = 4,
    parameter bit COMBINED     = 1'b0,
    parameter bit DMA_EN       = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic                    acc_write,
    input  logic                    acc_port,
    input  logic [2:0]              acc_size,
    input  logic [15:0]             acc_wdata,
    output logic                    acc_done,
    output logic                    acc_ok,
    output logic [8*DATA_BYTES-1:0] acc_rdata
);

    localparam int LEN_W  = $clog2(MAX_LEN + 1);
    localparam int ADDR_W = $clog2((GEN_ENTRIES + ARCH_ENTRIES) * MAX_LEN);

    logic                 cur_valid;
    logic                 cur_bank;
    logic [KEY_IDX_W-1:0] cur_idx;
    logic [OFF_W-1:0]     cur_offset;
    logic                 fsm_idle;
    logic                 item_present;
    logic [LEN_W-1:0]     item_len;
    logic [ADDR_W-1:0]    item_base;
    logic [ADDR_W-1:0]    rom_addr;
    logic [7:0]           rom_byte;
    logic                 unused_off_hi;

    assign unused_off_hi = ^cur_offset[OFF_W-1:LEN_W];

    cfg_item_table #(
        .GEN_ENTRIES (GEN_ENTRIES),
        .ARCH_ENTRIES(ARCH_ENTRIES),
        .MAX_LEN     (MAX_LEN)
    ) u_table (
        .sel_ok      (cur_valid),
        .sel_bank    (cur_bank),
        .sel_idx     (cur_idx),
        .item_present(item_present),
        .item_len    (item_len),
        .item_base   (item_base)
    );

    assign rom_addr = fsm_idle ? '0
                    : item_base + ADDR_W'(cur_offset[LEN_W-1:0]);

    cfg_byte_rom #(
        .GEN_ENTRIES (GEN_ENTRIES),
        .ARCH_ENTRIES(ARCH_ENTRIES),
        .MAX_LEN     (MAX_LEN),
        .DMA_EN      (DMA_EN)
    ) u_rom (
        .rd_addr(rom_addr),
        .rd_byte(rom_byte)
    );

    cfg_sel_fsm #(
        .GEN_ENTRIES (GEN_ENTRIES),
        .ARCH_ENTRIES(ARCH_ENTRIES),
        .MAX_LEN     (MAX_LEN),
        .DATA_BYTES  (DATA_BYTES),
        .COMBINED    (COMBINED)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .acc_port    (acc_port),
        .acc_size    (acc_size),
        .acc_wdata   (acc_wdata),
        .item_present(item_present),
        .item_len    (item_len),
        .item_byte   (rom_byte),
        .sel_ok      (cur_valid),
        .sel_bank    (cur_bank),
        .sel_idx     (cur_idx),
        .sel_off     (cur_offset),
        .fsm_idle    (fsm_idle),
        .acc_done    (acc_done),
        .acc_ok      (acc_ok),
        .acc_rdata   (acc_rdata)
    );

endmodule

// File: rtl/cfg_sel_port_chk.sv
module cfg_sel_port_chk #(
    parameter bit COMBINED = 1'b0,
    parameter int MAX_LEN  = 12,
    parameter int DW       = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid,
    input logic          acc_write,
    input logic          acc_port,
    input logic [2:0]    acc_size,
    input logic          acc_done,
    input logic          acc_ok,
    input logic [DW-1:0] acc_rdata,
    input logic          idle,
    input logic          sel_valid,
    input logic [31:0]   off_q
);

    logic take, take_sel;
    assign take     = idle && acc_valid;
    assign take_sel = take && acc_write && acc_size == 3'd2 && (COMBINED || !acc_port);

    a_r1_select_clears_offset: assert property (@(posedge clk) disable iff (!rst_n)
        take_sel |=> (off_q == 32'd0));

    a_r6_write_keeps_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (take && acc_write && !take_sel) |=> $stable(off_q));

    a_r2_ctl_read_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !acc_write && !COMBINED && !acc_port) |=> (acc_done && !acc_ok));

    a_r3_invalid_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && !sel_valid) |-> (acc_rdata == '0));

    a_r5_offset_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        off_q <= 32'(MAX_LEN));

    a_r4_offset_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !acc_done) |=> (off_q == $past(off_q) || off_q == $past(off_q) + 32'd1));

    a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done);

    a_r11_reject_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && !acc_ok) |-> (acc_rdata == '0));

endmodule

bind cfg_sel_port cfg_sel_port_chk #(
    .COMBINED(COMBINED),
    .MAX_LEN (MAX_LEN),
    .DW      (8 * DATA_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .acc_port (acc_port),
    .acc_size (acc_size),
    .acc_done (acc_done),
    .acc_ok   (acc_ok),
    .acc_rdata(acc_rdata),
    .idle     (fsm_idle),
    .sel_valid(cur_valid),
    .off_q    (cur_offset)
);

// File: tb/test_cfg_sel_port.sv
`timescale 1ns/1ps
module test_cfg_sel_port;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // unit 0: split layout, unit 1: combined layout
    logic        a_valid = 0, a_write = 0, a_port = 0;
    logic [2:0]  a_size = 0;
    logic [15:0] a_wdata = 0;
    logic        a_done, a_ok;
    logic [31:0] a_rdata;
    logic        b_valid = 0, b_write = 0, b_port = 0;
    logic [2:0]  b_size = 0;
    logic [15:0] b_wdata = 0;
    logic        b_done, b_ok;
    logic [31:0] b_rdata;

    cfg_sel_port #(.GEN_ENTRIES(8), .ARCH_ENTRIES(4), .MAX_LEN(12),
                   .DATA_BYTES(4), .COMBINED(1'b0), .DMA_EN(1'b1)) i_cfg_sel_port (
        .clk(clk), .rst_n(rst_n), .acc_valid(a_valid), .acc_write(a_write),
        .acc_port(a_port), .acc_size(a_size), .acc_wdata(a_wdata),
        .acc_done(a_done), .acc_ok(a_ok), .acc_rdata(a_rdata));

    cfg_sel_port #(.GEN_ENTRIES(8), .ARCH_ENTRIES(2), .MAX_LEN(10),
                   .DATA_BYTES(4), .COMBINED(1'b1), .DMA_EN(1'b0)) i_cfg_sel_port_comb (
        .clk(clk), .rst_n(rst_n), .acc_valid(b_valid), .acc_write(b_write),
        .acc_port(b_port), .acc_size(b_size), .acc_wdata(b_wdata),
        .acc_done(b_done), .acc_ok(b_ok), .acc_rdata(b_rdata));

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic        u;
        logic        wr;
        logic        port;
        logic [2:0]  sz;
        logic [15:0] wd;
        logic        ok;
        logic [31:0] rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VECS [NV] = '{
        '{0,0,1,3'd4,16'h0000,1,32'h51454D55, 4'd8},  // R8 signature after reset
        '{0,0,1,3'd2,16'h0000,1,32'h00000000, 4'd5},  // R5 at end of item
        '{0,1,0,3'd2,16'h0001,1,32'h00000000, 4'd1},  // R1 select id
        '{0,0,1,3'd4,16'h0000,1,32'h03000000, 4'd9},  // R9 id with DMA_EN=1
        '{0,1,0,3'd2,16'h0003,1,32'h00000000, 4'd1},  // R1
        '{0,0,1,3'd3,16'h0000,1,32'h00303132, 4'd4},  // R4 3-byte packing
        '{0,0,1,3'd2,16'h0000,1,32'h00003300, 4'd5},  // R5 zero pad
        '{0,1,0,3'd2,16'h4001,1,32'h00000000, 4'd1},  // R1 arch bank
        '{0,0,1,3'd4,16'h0000,1,32'h90919293, 4'd10}, // R10 arch content
        '{0,1,1,3'd1,16'h00FF,1,32'h00000000, 4'd6},  // R6 data write accepted
        '{0,0,1,3'd4,16'h0000,1,32'h94959600, 4'd6},  // R6 offset kept, R5 pad
        '{0,0,1,3'd1,16'h0000,1,32'h00000000, 4'd5},  // R5 read at end
        '{0,1,0,3'd2,16'h4001,1,32'h00000000, 4'd1},  // R1 reselect
        '{0,0,0,3'd2,16'h0000,0,32'h00000000, 4'd2},  // R2 control read
        '{0,1,0,3'd4,16'h0000,0,32'h00000000, 4'd2},  // R2 4-byte control write
        '{0,1,0,3'd1,16'h0005,0,32'h00000000, 4'd2},  // R2 1-byte control write
        '{0,0,1,3'd1,16'h0000,1,32'h00000090, 4'd2},  // R2 selection kept
        '{0,1,0,3'd2,16'h0008,1,32'h00000000, 4'd3},  // R3 generic index 8
        '{0,0,1,3'd4,16'h0000,1,32'h00000000, 4'd3},  // R3
        '{0,1,0,3'd2,16'h4004,1,32'h00000000, 4'd3},  // R3 arch index 4
        '{0,0,1,3'd1,16'h0000,1,32'h00000000, 4'd3},  // R3
        '{0,1,0,3'd2,16'h0002,1,32'h00000000, 4'd10}, // R10 absent item
        '{0,0,1,3'd2,16'h0000,1,32'h00000000, 4'd10}, // R10
        '{0,1,0,3'd2,16'h8007,1,32'h00000000, 4'd1},  // R1 bit 15 ignored
        '{0,0,1,3'd2,16'h0000,1,32'h00007071, 4'd10}, // R10
        '{0,0,1,3'd0,16'h0000,0,32'h00000000, 4'd12}, // R12 size 0
        '{0,0,1,3'd5,16'h0000,0,32'h00000000, 4'd12}, // R12 size 5
        '{0,0,1,3'd1,16'h0000,1,32'h00000072, 4'd12}, // R12 offset unmoved
        '{0,1,0,3'd2,16'h4003,1,32'h00000000, 4'd1},  // R1
        '{0,0,1,3'd4,16'h0000,1,32'h00B0B1B2 << 8 | 32'h000000B3, 4'd10}, // R10
        '{0,1,1,3'd2,16'h0001,1,32'h00000000, 4'd6},  // R6 2-byte data write ignored
        '{0,0,1,3'd1,16'h0000,1,32'h000000B4, 4'd6},  // R6
        '{1,0,0,3'd1,16'h0000,1,32'h00000051, 4'd7},  // R7 byte read, port ignored
        '{1,0,1,3'd1,16'h0000,1,32'h00000045, 4'd7},  // R7
        '{1,1,0,3'd2,16'h0001,1,32'h00000000, 4'd7},  // R7 2-byte write selects
        '{1,0,0,3'd1,16'h0000,1,32'h00000001, 4'd9},  // R9 DMA_EN=0
        '{1,0,0,3'd1,16'h0000,1,32'h00000000, 4'd9},  // R9
        '{1,0,0,3'd2,16'h0000,0,32'h00000000, 4'd7},  // R7 2-byte read rejected
        '{1,1,0,3'd1,16'h00AA,1,32'h00000000, 4'd7},  // R7 byte write ignored
        '{1,1,0,3'd4,16'h4001,0,32'h00000000, 4'd7},  // R7 4-byte write rejected
        '{1,1,0,3'd2,16'h4001,1,32'h00000000, 4'd7},  // R7
        '{1,0,0,3'd1,16'h0000,1,32'h00000090, 4'd10}, // R10
        '{1,0,0,3'd1,16'h0000,1,32'h00000091, 4'd4},  // R4 offset advanced
        '{1,1,0,3'd2,16'h4002,1,32'h00000000, 4'd3},  // R3 arch index 2 of 2
        '{1,0,0,3'd1,16'h0000,1,32'h00000000, 4'd3},  // R3
        '{1,1,0,3'd2,16'h0007,1,32'h00000000, 4'd7}   // R7
    };

    task automatic access(input logic u, input logic wr, input logic port,
                          input logic [2:0] sz, input logic [15:0] wd,
                          output logic ok, output logic [31:0] rd, output logic got);
        @(negedge clk);
        if (!u) begin a_valid = 1; a_write = wr; a_port = port; a_size = sz; a_wdata = wd; end
        else    begin b_valid = 1; b_write = wr; b_port = port; b_size = sz; b_wdata = wd; end
        @(negedge clk);
        a_valid = 0; b_valid = 0;
        got = 0; ok = 0; rd = 0;
        for (int i = 0; i < 16; i++) begin
            if (!u ? a_done : b_done) begin
                got = 1;
                ok  = !u ? a_ok : b_ok;
                rd  = !u ? a_rdata : b_rdata;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    logic        r_ok, r_got;
    logic [31:0] r_rd;

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(11, "reset done", {31'd0, a_done}, 32'd0);
        check(11, "reset ok", {31'd0, a_ok}, 32'd0);
        check(11, "reset rdata", a_rdata, 32'd0);
        rst_n = 1;

        foreach (VECS[n]) begin
            access(VECS[n].u, VECS[n].wr, VECS[n].port, VECS[n].sz, VECS[n].wd,
                   r_ok, r_rd, r_got);
            check(11, $sformatf("vec %0d done seen", n), {31'd0, r_got}, 32'd1);
            check(int'(VECS[n].req), $sformatf("vec %0d ok", n), {31'd0, r_ok}, {31'd0, VECS[n].ok});
            check(int'(VECS[n].req), $sformatf("vec %0d rdata", n), r_rd, VECS[n].rd);
        end

        // R11: done drops the cycle after it rises
        access(0, 1, 0, 3'd2, 16'h0005, r_ok, r_rd, r_got);
        @(negedge clk);
        check(11, "done width", {31'd0, a_done}, 32'd0);
        check(11, "ok outside done", {31'd0, a_ok}, 32'd0);
        access(0, 0, 1, 3'd1, 16'h0000, r_ok, r_rd, r_got);
        check(10, "gen 5 byte 0", r_rd, 32'h00000050);

        // R8: a new reset returns to the signature item at offset 0
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        access(0, 0, 1, 3'd4, 16'h0000, r_ok, r_rd, r_got);
        check(8, "signature after re-reset", r_rd, 32'h51454D55);
        access(1, 0, 0, 3'd1, 16'h0000, r_ok, r_rd, r_got);
        check(8, "combined signature byte", r_rd, 32'h00000051);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule